// File: doc/BRIEF.md
# TDM Codec Serial Slot Engine

This block is a multichannel time-division serial port that exchanges audio words with a codec. It runs on the system clock and watches an external bit clock and frame sync. A bit counter and a slot counter step on each rising bit-clock edge. A frame sync seen at a rising edge restarts both counters at zero. Each slot carries one word of programmable length. The slot counter rolls through a programmable number of slots.

Only slots whose enable bit is set exchange data. Each enabled slot takes the next word from a transmit shadow bank and deposits the received word into the matching receive shadow entry. After a programmable number of words, both banks swap with the processor-side buffers in one transfer, and the block raises a one-cycle interrupt. At that transfer, a transmit location the processor left unwritten sends either silence or its last written word. Unused slots drive the line low or release it, so several devices can share one data line. An internal loopback feeds the serial output back to the receiver. An idle-stop option freezes the engine while an idle request is present.

Top module: `tdm_slot_engine`

## Requirements
- R1: A frame sync high at a rising bit-clock edge sets slot 0, bit 0. Otherwise each rising edge advances the bit. After bit `word_last_i` the slot advances, and after slot `slot_last_i` it wraps to 0. `slot_o` always shows the current slot.
- R2: In a slot whose bit in `slot_en_i` is 1, `sdo_o` presents the word MSB first: word bit `word_last_i` in the slot's first bit period, down to bit 0. `sdo_o` updates at the rising bit-clock edge, and `sdo_oe_o` is 1.
- R3: With `hiz_unused_i`=0, a slot whose enable bit is 0 drives `sdo_o`=0 with `sdo_oe_o`=1.
- R4: With `hiz_unused_i`=1, a slot whose enable bit is 0 gives `sdo_oe_o`=0 and `sdo_o`=0.
- R5: With `loopback_i`=1, the receiver takes the transmitted bits, and `sdi_i` has no effect on the received words.
- R6: Input is sampled at falling bit-clock edges, MSB first. A received word is stored right-aligned in `word_last_i`+1 bits, with the upper bits zero.
- R7: Enabled slots use buffer locations 0, 1, … in order. After `blen_i`+1 words, the block makes one transfer: transmit buffers move to the transmit shadow, received words move to the read buffers, and `irq_o` pulses high for one clock.
- R8: At a transfer, a transmit location not written since the previous transfer loads zero into its shadow when `unf_repeat_i`=0.
- R9: In the same underflow case with `unf_repeat_i`=1, the shadow reloads the last word written to that location.
- R10: While `idle_stop_i`=1 and `idle_req_i`=1, bit-clock edges are ignored and the slot counter holds.
- R11: With `idle_stop_i`=0, `idle_req_i` has no effect and the engine keeps counting.
- R12: After reset, `sdo_o`=0, `sdo_oe_o`=0, `slot_o`=0, `irq_o`=0, and every buffer reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sck_i | input | 1 | Serial bit clock |
| fs_i | input | 1 | Frame sync, sampled at rising bit-clock edges |
| sdi_i | input | 1 | Serial data in |
| slot_en_i | input | SLOT_N | Per-slot enable |
| slot_last_i | input | SLOT_W | Number of slots per frame minus one |
| word_last_i | input | BIT_W | Word length minus one |
| blen_i | input | IDX_W | Words per transfer minus one |
| hiz_unused_i | input | 1 | 1: release the line in unused slots |
| unf_repeat_i | input | 1 | 1: repeat the last word on underflow |
| loopback_i | input | 1 | Internal loopback |
| idle_stop_i | input | 1 | Halt while idle is requested |
| idle_req_i | input | 1 | Idle request |
| wr_en_i | input | 1 | Transmit buffer write strobe |
| wr_idx_i | input | IDX_W | Transmit buffer location |
| wr_data_i | input | WORD_W | Transmit word |
| rd_idx_i | input | IDX_W | Receive buffer location |
| rd_data_o | output | WORD_W | Receive word at `rd_idx_i` |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for `sdo_o` |
| slot_o | output | SLOT_W | Current slot |
| irq_o | output | 1 | One-clock transfer interrupt |

## Verification
The bench covers word lengths from 4 to the full 20 bits, including a word wider than the configured length. A design that forgot the receive mask would return stray high bits. Loopback runs while `sdi_i` is held at 1, so a leaky input mux turns zeros into ones. A two-word transfer is followed by frames with no processor writes, once in each underflow mode; a design that mishandled the written flags would resend stale data or send silence in the wrong mode. Idle-stop, slot wrap without a frame sync, and released-line slots are each checked, because a wrong design would keep counting, stick at the last slot, or keep driving a shared line.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } sck_evt_t;
endpackage

// File: rtl/tdm_frame_ctr.sv
module tdm_frame_ctr #(
  parameter int BIT_W  = 5,
  parameter int SLOT_W = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                sck_i,
  input  logic                fs_i,
  input  logic                halt_i,
  input  logic [BIT_W-1:0]    word_last_i,
  input  logic [SLOT_W-1:0]   slot_last_i,
  output tdm_pkg::sck_evt_t   evt_o,
  output logic [BIT_W-1:0]    bit_o,
  output logic [BIT_W-1:0]    nxt_bit_o,
  output logic [SLOT_W-1:0]   slot_o,
  output logic [SLOT_W-1:0]   nxt_slot_o
);
  logic sck_q;
  logic [BIT_W-1:0]  bit_q;
  logic [SLOT_W-1:0] slot_q;

  assign evt_o.rise = sck_i & ~sck_q & ~halt_i;
  assign evt_o.fall = ~sck_i & sck_q & ~halt_i;

  always_comb begin
    nxt_bit_o  = bit_q + BIT_W'(1);
    nxt_slot_o = slot_q;
    if (fs_i) begin
      nxt_bit_o  = '0;
      nxt_slot_o = '0;
    end else if (bit_q == word_last_i) begin
      nxt_bit_o  = '0;
      nxt_slot_o = (slot_q == slot_last_i) ? '0 : slot_q + SLOT_W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_q  <= 1'b0;
      bit_q  <= '0;
      slot_q <= '0;
    end else begin
      sck_q <= sck_i;
      if (evt_o.rise) begin
        bit_q  <= nxt_bit_o;
        slot_q <= nxt_slot_o;
      end
    end
  end

  assign bit_o  = bit_q;
  assign slot_o = slot_q;

  // R1
  fs_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.rise && fs_i |=> (slot_o == '0) && (bit_o == '0));
  // R1
  slot_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o.rise && !fs_i && (bit_o == word_last_i) && (slot_o == slot_last_i) |=> slot_o == '0);
  // R10
  halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i |=> $stable(slot_o) && $stable(bit_o));
endmodule

// File: rtl/tdm_xfer_ctl.sv
module tdm_xfer_ctl #(
  parameter int BIT_W  = 5,
  parameter int SLOT_N = 16,
  parameter int SLOT_W = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic [BIT_W-1:0]  bit_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic [BIT_W-1:0]  word_last_i,
  input  logic [SLOT_N-1:0] slot_en_i,
  input  logic [IDX_W-1:0]  blen_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              store_o,
  output logic              xfer_o,
  output logic              irq_o
);
  logic [IDX_W-1:0] idx_q;
  logic             irq_q;

  // last bit of an enabled slot has been sampled
  assign store_o = fall_i && (bit_i == word_last_i) && slot_en_i[slot_i];
  assign xfer_o  = store_o && (idx_q >= blen_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      idx_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= xfer_o;
      if (store_o) idx_q <= xfer_o ? '0 : idx_q + IDX_W'(1);
    end
  end

  assign idx_o = idx_q;
  assign irq_o = irq_q;

  // R7
  irq_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);
  // R7
  idx_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_o |=> idx_o == '0);
endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path #(
  parameter int WORD_W = 20,
  parameter int BIT_W  = 5,
  parameter int SLOT_N = 16,
  parameter int SLOT_W = 4,
  parameter int BUF_N  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  blen_i,
  input  logic              xfer_i,
  input  logic              unf_repeat_i,
  input  logic              rise_i,
  input  logic [BIT_W-1:0]  nxt_bit_i,
  input  logic [SLOT_W-1:0] nxt_slot_i,
  input  logic [BIT_W-1:0]  word_last_i,
  input  logic [SLOT_N-1:0] slot_en_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              hiz_i,
  output logic              sdo_o,
  output logic              oe_o
);
  logic [WORD_W-1:0] buf_q    [BUF_N];
  logic [WORD_W-1:0] shadow_q [BUF_N];
  logic [BUF_N-1:0]  fresh_q;
  logic [WORD_W-1:0] cur_w;
  logic [BIT_W-1:0]  pos;
  logic              nxt_en;
  logic              sdo_q, oe_q;

  assign cur_w  = shadow_q[idx_i];
  assign pos    = word_last_i - nxt_bit_i;
  assign nxt_en = slot_en_i[nxt_slot_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < BUF_N; i++) begin
        buf_q[i]    <= '0;
        shadow_q[i] <= '0;
      end
      fresh_q <= '0;
    end else begin
      for (int i = 0; i < BUF_N; i++) begin
        if (wr_en_i && (int'(wr_idx_i) == i)) buf_q[i] <= wr_data_i;
        if (xfer_i && (i <= int'(blen_i))) begin
          // unwritten location: repeat or silence
          shadow_q[i] <= (fresh_q[i] || unf_repeat_i) ? buf_q[i] : '0;
          fresh_q[i]  <= wr_en_i && (int'(wr_idx_i) == i);
        end else if (wr_en_i && (int'(wr_idx_i) == i)) begin
          fresh_q[i] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else if (rise_i) begin
      sdo_q <= nxt_en ? cur_w[pos] : 1'b0;
      oe_q  <= nxt_en | ~hiz_i;
    end
  end

  assign sdo_o = sdo_q;
  assign oe_o  = oe_q;

  // R4
  quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !oe_o |-> !sdo_o);
  // R3
  low_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i && !slot_en_i[nxt_slot_i] |=> !sdo_o);
  // R3
  drive_unused_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_i && !hiz_i |=> oe_o);
endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path #(
  parameter int WORD_W = 20,
  parameter int BIT_W  = 5,
  parameter int BUF_N  = 4,
  parameter int IDX_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              sdi_i,
  input  logic              store_i,
  input  logic              xfer_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [BIT_W-1:0]  word_last_i,
  input  logic [IDX_W-1:0]  blen_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o
);
  logic [WORD_W-1:0] sh_q, sh_nxt, mask, word_new;
  logic [WORD_W-1:0] shadow_q [BUF_N];
  logic [WORD_W-1:0] rbuf_q   [BUF_N];

  assign sh_nxt   = {sh_q[WORD_W-2:0], sdi_i};
  assign mask     = {WORD_W{1'b1}} >> (WORD_W - 1 - int'(word_last_i));
  assign word_new = sh_nxt & mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      for (int i = 0; i < BUF_N; i++) begin
        shadow_q[i] <= '0;
        rbuf_q[i]   <= '0;
      end
    end else begin
      if (fall_i) sh_q <= sh_nxt;
      if (store_i) shadow_q[idx_i] <= word_new;
      if (xfer_i) begin
        for (int i = 0; i < BUF_N; i++) begin
          // word finishing this cycle bypasses its shadow entry
          if (i <= int'(blen_i))
            rbuf_q[i] <= (i == int'(idx_i)) ? word_new : shadow_q[i];
        end
      end
    end
  end

  assign rd_data_o = rbuf_q[rd_idx_i];

  // R6
  rx_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    xfer_i && (rd_idx_i == idx_i) |=>
      ($past(rd_idx_i) != rd_idx_i) || ((rd_data_o & ~$past(mask)) == '0));
endmodule

// File: rtl/tdm_slot_engine.sv
module tdm_slot_engine #(
  parameter int WORD_W = 20,
  parameter int SLOT_N = 16,
  parameter int BUF_N  = 4,
  localparam int BIT_W  = $clog2(WORD_W),
  localparam int SLOT_W = $clog2(SLOT_N),
  localparam int IDX_W  = $clog2(BUF_N)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sck_i,
  input  logic              fs_i,
  input  logic              sdi_i,
  input  logic [SLOT_N-1:0] slot_en_i,
  input  logic [SLOT_W-1:0] slot_last_i,
  input  logic [BIT_W-1:0]  word_last_i,
  input  logic [IDX_W-1:0]  blen_i,
  input  logic              hiz_unused_i,
  input  logic              unf_repeat_i,
  input  logic              loopback_i,
  input  logic              idle_stop_i,
  input  logic              idle_req_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [WORD_W-1:0] wr_data_i,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              sdo_o,
  output logic              sdo_oe_o,
  output logic [SLOT_W-1:0] slot_o,
  output logic              irq_o
);
  tdm_pkg::sck_evt_t evt;
  logic [BIT_W-1:0]  bit_cur, bit_nxt;
  logic [SLOT_W-1:0] slot_cur, slot_nxt;
  logic [IDX_W-1:0]  idx;
  logic              store, xfer, halt, sdi_eff, sdo_int;

  assign halt    = idle_stop_i & idle_req_i;
  assign sdi_eff = loopback_i ? sdo_int : sdi_i;

  tdm_frame_ctr #(.BIT_W(BIT_W), .SLOT_W(SLOT_W)) u_frame (
    .clk_i, .rst_ni, .sck_i, .fs_i, .halt_i(halt),
    .word_last_i, .slot_last_i,
    .evt_o(evt), .bit_o(bit_cur), .nxt_bit_o(bit_nxt),
    .slot_o(slot_cur), .nxt_slot_o(slot_nxt)
  );

  tdm_xfer_ctl #(.BIT_W(BIT_W), .SLOT_N(SLOT_N), .SLOT_W(SLOT_W), .IDX_W(IDX_W)) u_xfer (
    .clk_i, .rst_ni, .fall_i(evt.fall), .bit_i(bit_cur), .slot_i(slot_cur),
    .word_last_i, .slot_en_i, .blen_i,
    .idx_o(idx), .store_o(store), .xfer_o(xfer), .irq_o
  );

  tdm_tx_path #(.WORD_W(WORD_W), .BIT_W(BIT_W), .SLOT_N(SLOT_N), .SLOT_W(SLOT_W),
                .BUF_N(BUF_N), .IDX_W(IDX_W)) u_tx (
    .clk_i, .rst_ni, .wr_en_i, .wr_idx_i, .wr_data_i, .blen_i,
    .xfer_i(xfer), .unf_repeat_i, .rise_i(evt.rise),
    .nxt_bit_i(bit_nxt), .nxt_slot_i(slot_nxt), .word_last_i, .slot_en_i,
    .idx_i(idx), .hiz_i(hiz_unused_i), .sdo_o(sdo_int), .oe_o(sdo_oe_o)
  );

  tdm_rx_path #(.WORD_W(WORD_W), .BIT_W(BIT_W), .BUF_N(BUF_N), .IDX_W(IDX_W)) u_rx (
    .clk_i, .rst_ni, .fall_i(evt.fall), .sdi_i(sdi_eff), .store_i(store),
    .xfer_i(xfer), .idx_i(idx), .word_last_i, .blen_i, .rd_idx_i, .rd_data_o
  );

  assign sdo_o  = sdo_int;
  assign slot_o = slot_cur;
endmodule

// File: tb/tdm_slot_engine_test.sv
module tdm_slot_engine_test;
  localparam int WORD_W = 20;
  localparam int SLOT_N = 16;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic sck = 1'b0, fs = 1'b0, sdi = 1'b0;
  logic [15:0] slot_en = '0;
  logic [3:0]  slot_last = '0;
  logic [4:0]  word_last = 5'd15;
  logic [1:0]  blen = '0;
  logic hiz = 1'b0, unf = 1'b0, loop = 1'b0, istop = 1'b0, ireq = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0]  wr_idx = '0, rd_idx = '0;
  logic [19:0] wr_data = '0;
  logic [19:0] rd_data;
  logic sdo, oe, irq;
  logic [3:0] slot;

  int checks = 0, fails = 0, irq_cnt = 0, bad_drive = 0, bad_slot = 0;
  logic [19:0] cap [16];
  logic [19:0] rx_pat = '1;
  bit done = 0;

  always #4 clk = ~clk;

  tdm_slot_engine uut (
    .clk_i(clk), .rst_ni, .sck_i(sck), .fs_i(fs), .sdi_i(sdi),
    .slot_en_i(slot_en), .slot_last_i(slot_last), .word_last_i(word_last),
    .blen_i(blen), .hiz_unused_i(hiz), .unf_repeat_i(unf), .loopback_i(loop),
    .idle_stop_i(istop), .idle_req_i(ireq), .wr_en_i(wr_en), .wr_idx_i(wr_idx),
    .wr_data_i(wr_data), .rd_idx_i(rd_idx), .rd_data_o(rd_data),
    .sdo_o(sdo), .sdo_oe_o(oe), .slot_o(slot), .irq_o(irq)
  );

  always @(negedge clk) if (irq) irq_cnt++;

  typedef struct packed {
    logic [4:0]  wl;
    logic [3:0]  sl;
    logic [3:0]  es;
    logic [19:0] w;
  } vec_t;

  localparam vec_t VEC [6] = '{
    '{5'd15, 4'd3, 4'd1, 20'h0A5C3},
    '{5'd7,  4'd1, 4'd0, 20'h000B6},
    '{5'd19, 4'd2, 4'd2, 20'hF0F0E},
    '{5'd3,  4'd5, 4'd5, 20'h00009},
    '{5'd11, 4'd0, 4'd0, 20'h00A3C},
    '{5'd15, 4'd3, 4'd3, 20'h12345}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_tx(input logic [1:0] idx, input logic [19:0] d);
    @(negedge clk); wr_en = 1'b1; wr_idx = idx; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic read_rx(input logic [1:0] idx, output logic [19:0] d);
    @(negedge clk); rd_idx = idx; #1 d = rd_data;
  endtask

  task automatic pulse(input logic f, input logic din, output logic so,
                       output logic soe, output logic [3:0] sl);
    @(negedge clk); sck = 1'b1; fs = f; sdi = din;
    @(negedge clk); so = sdo; soe = oe; sl = slot;
    @(negedge clk); sck = 1'b0; fs = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame();
    logic so, soe;
    logic [3:0] sl;
    for (int s = 0; s < 16; s++) cap[s] = '0;
    for (int s = 0; s <= int'(slot_last); s++) begin
      for (int b = 0; b <= int'(word_last); b++) begin
        pulse((s == 0) && (b == 0), rx_pat[int'(word_last) - b], so, soe, sl);
        if (sl !== 4'(s)) bad_slot++;
        if (slot_en[s]) begin
          cap[s] = {cap[s][18:0], so};
          if (soe !== 1'b1) bad_drive++;
        end else if (hiz) begin
          if (soe !== 1'b0 || so !== 1'b0) bad_drive++;
        end else if (soe !== 1'b1 || so !== 1'b0) bad_drive++;
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [19:0] rd, mask;
    logic so, soe;
    logic [3:0] sl;
    int irq0;

    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 sdo", 32'(sdo), 0);
    chk("R12 oe", 32'(oe), 0);
    chk("R12 slot", 32'(slot), 0);
    chk("R12 irq", 32'(irq), 0);
    read_rx(2'd0, rd);
    chk("R12 rd_data", 32'(rd), 0);

    // vector walk: loopback with sdi_i held high
    loop = 1'b1; rx_pat = '1;
    for (int v = 0; v < 6; v++) begin
      word_last = VEC[v].wl; slot_last = VEC[v].sl;
      slot_en = 16'(1) << VEC[v].es;
      mask = 20'((32'd1 << (int'(VEC[v].wl) + 1)) - 1);
      write_tx(2'd0, VEC[v].w);
      bad_drive = 0; bad_slot = 0;
      run_frame();
      run_frame();
      chk("R2 tx word", 32'(cap[VEC[v].es]), 32'(VEC[v].w & mask));
      chk("R3 unused low", bad_drive, 0);
      chk("R1 slot count", bad_slot, 0);
      read_rx(2'd0, rd);
      chk("R5 loopback rx", 32'(rd), 32'(VEC[v].w & mask));
    end

    // R6 external receive, falling-edge sampling, right aligned
    loop = 1'b0; word_last = 5'd11; slot_last = 4'd2; slot_en = 16'h0002;
    rx_pat = 20'hFF5A3;
    run_frame();
    read_rx(2'd0, rd);
    chk("R6 rx word", 32'(rd), 32'h5A3);

    // R7 two-word transfers with loopback
    loop = 1'b1; rx_pat = '1; word_last = 5'd7; slot_last = 4'd3;
    slot_en = 16'h0006; blen = 2'd1;
    write_tx(2'd0, 20'h0003C);
    write_tx(2'd1, 20'h000A5);
    irq0 = irq_cnt;
    run_frame();
    run_frame();
    chk("R7 slot1 word", 32'(cap[1]), 32'h3C);
    chk("R7 slot2 word", 32'(cap[2]), 32'hA5);
    chk("R7 irq count", irq_cnt - irq0, 2);
    read_rx(2'd0, rd);
    chk("R7 rx loc0", 32'(rd), 32'h3C);
    read_rx(2'd1, rd);
    chk("R7 rx loc1", 32'(rd), 32'hA5);

    // R8 underflow sends silence, R9 underflow repeats
    unf = 1'b1;
    run_frame();
    chk("R8 silence loc0", 32'(cap[1]), 0);
    chk("R8 silence loc1", 32'(cap[2]), 0);
    run_frame();
    chk("R9 repeat loc0", 32'(cap[1]), 32'h3C);
    chk("R9 repeat loc1", 32'(cap[2]), 32'hA5);
    unf = 1'b0;

    // R4 released line in unused slots
    hiz = 1'b1; bad_drive = 0;
    run_frame();
    chk("R4 unused released", bad_drive, 0);
    hiz = 1'b0;

    // R1 wrap without frame sync
    pulse(1'b0, 1'b0, so, soe, sl);
    chk("R1 wrap slot", 32'(sl), 0);

    // R10 halt, R11 idle request ignored when stop disabled
    run_frame();
    chk("R10 pre-halt slot", 32'(slot), 3);
    istop = 1'b1; ireq = 1'b1; irq0 = irq_cnt;
    for (int k = 0; k < 3; k++) pulse(1'b1, 1'b0, so, soe, sl);
    chk("R10 halted slot", 32'(sl), 3);
    chk("R10 halted irq", irq_cnt - irq0, 0);
    istop = 1'b0;
    pulse(1'b1, 1'b0, so, soe, sl);
    chk("R11 running slot", 32'(sl), 0);
    ireq = 1'b0;

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule